// File: doc/BRIEF.md
# Power-Management Event Register Block

This block is a small I/O-mapped register window that collects power-management events and turns them into a single level interrupt for system software. It keeps a 16-bit event status word, a 16-bit event enable word, a 32-bit SMI enable word and a bank of eight bytes of general-purpose event state: four status bytes and four enable bytes. Hardware event strobes, a power-down request and the overflow of an internal free-running timer set status bits. Software clears them by writing ones. The interrupt output is high while any of four selected status bits is set together with its enable.

The window is 64 bytes long and can be moved. A separate base port loads its base address. While the base is zero the window answers no access at all. The bus carries a dword-aligned address with four byte enables, so an access is 1, 2 or 4 bytes wide. A register that is not built for the width of an access sees it as narrower pieces on consecutive addresses, lowest address in the least significant lane. Reads are combinational and have no side effects.

Top module: `pmEventBlock`

## Requirements
- R1: While `rstN` is low, the base, all status and enable words, the SMI word, the general-purpose bytes and the timer counter are cleared to zero, and `sci` is low.
- R2: `sci` equals the OR over bits 0 (timer), 5 (global lock), 8 (power button) and 10 (clock alarm) of status AND enable. No other bit affects it, and it follows a register write in the cycle after the write edge.
- R3: Event status (offset 0x00) is write-one-to-clear. Bit k is set by `evtSet[k]`, bit 8 by `pwrDownReq` and bit 0 by timer overflow. A set in the same cycle as a clear wins.
- R4: The status word (lanes 0-1) and the enable word (offset 0x02, lanes 2-3) respond only to 2-byte and 4-byte accesses. A 4-byte write at 0x00 updates both. 1-byte accesses there read zero and change nothing.
- R5: The SMI enable word at offset 0x30 is read and written only by 4-byte accesses and keeps the value written. Narrower accesses read zero and change nothing.
- R6: General-purpose status bytes at 0x20-0x23 are write-one-to-clear, and `gpeEvt` bits set them with priority over the clear. Enable bytes at 0x24-0x27 keep the value written. Byte 0x20+i uses lane i under any access width.
- R7: Reads of unmapped offsets return zero and writes there are ignored. An access whose address has bits [1:0] non-zero, or whose byte enables are not 0001, 0010, 0100, 1000, 0011, 1100 or 1111, is ignored and reads zero.
- R8: With the base at zero nothing is decoded. A base write loads `baseIn` with its low six bits forced to zero. An access hits when `busAddr[15:6]` equals the base's upper bits.
- R9: The timer counter is TMR_W bits wide and starts at zero. Status bit 0 is set on the edge where the counter's top bit toggles, that is every 2^(TMR_W-1) cycles, whatever the enable. It raises `sci` only while enable bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseWe | input | 1 | Load the window base from `baseIn` |
| baseIn | input | ADDR_W | New window base; the low BLK_BITS bits are dropped |
| busAddr | input | ADDR_W | Dword-aligned access address |
| busWe | input | 1 | Write access |
| busRe | input | 1 | Read access |
| busBe | input | 4 | Byte enables, lane i = address + i |
| busWdata | input | 32 | Write data, little-endian lanes |
| busRdata | output | 32 | Read data, zero when nothing is read |
| evtSet | input | 16 | Hardware strobes that set event status bits |
| pwrDownReq | input | 1 | Power-down request, sets status bit 8 |
| gpeEvt | input | 32 | Strobes that set general-purpose status bits |
| sci | output | 1 | Level interrupt request |

## Verification
The bench targets the width rules. A byte write to the status word must not clear anything, and a 2-byte access to the SMI word must read back zero. A decoder that forwarded every lane would accept both. A status clear written in the same cycle as a power-button or timer event must lose, or the event vanishes without an interrupt. The bench also checks that non-mask status bits leave `sci` low even with every enable set, that a zeroed base hides the window while an unaligned base is treated as aligned, and that the timer flag appears in exactly the predicted cycle whether or not its enable is set. A reference model is compared against the read data and `sci` in every cycle of the directed and random sequences.

// File: rtl/pmEventPkg.sv
package pmEventPkg;

  localparam int GPE_BYTES = 4;
  localparam int GPE_SPAN  = 2 * GPE_BYTES;
  localparam int GPE_OFF   = 32;
  localparam int SMI_OFF   = 48;

  localparam int TMR_BIT = 0;
  localparam int GLK_BIT = 5;
  localparam int PWR_BIT = 8;
  localparam int RTC_BIT = 10;

  localparam logic [15:0] SCI_MASK = (16'd1 << TMR_BIT) | (16'd1 << GLK_BIT) |
                                     (16'd1 << PWR_BIT) | (16'd1 << RTC_BIT);

  typedef struct packed {
    logic                wrSts;
    logic                wrEna;
    logic                wrSmi;
    logic                rdSts;
    logic                rdEna;
    logic                rdSmi;
    logic [GPE_SPAN-1:0] gpeWr;
    logic [GPE_SPAN-1:0] gpeRd;
  } pmStrobeT;

endpackage

// File: rtl/pmCtrl.sv
module pmCtrl
  import pmEventPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLK_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [3:0]        busBe,
  output pmStrobeT          stb
);

  localparam int DW_W = BLK_BITS - 2;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << BLK_BITS) - 1);
  localparam logic [DW_W-1:0] SMI_DW = DW_W'(SMI_OFF / 4);

  logic [ADDR_W-1:0] baseReg;
  logic              hit;
  logic [DW_W-1:0]   dw;
  logic              size1, size2, size4, sizeOk;
  logic              smiDw, pm1Dw, dwNative, pm1Word;
  logic              wrAcc, rdAcc;
  logic [3:0]        byteLane;
  logic [GPE_SPAN-1:0] gpeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       baseReg <= '0;
    else if (baseWe) baseReg <= baseIn & ~LOW_MASK;
  end

  assign hit = (baseReg != '0) && (busAddr[1:0] == 2'b00) &&
               (busAddr[ADDR_W-1:BLK_BITS] == baseReg[ADDR_W-1:BLK_BITS]);
  assign dw  = busAddr[BLK_BITS-1:2];

  // access width from the byte-enable pattern
  assign size1  = $countones(busBe) == 1;
  assign size2  = (busBe == 4'b0011) || (busBe == 4'b1100);
  assign size4  = (busBe == 4'b1111);
  assign sizeOk = size1 || size2 || size4;

  // native handlers: dword at the SMI slot, words at dword 0
  assign smiDw    = (dw == SMI_DW);
  assign pm1Dw    = (dw == '0);
  assign dwNative = size4 && smiDw;
  assign pm1Word  = (size2 || (size4 && !smiDw)) && pm1Dw;

  // anything not taken natively falls through to byte handling
  always_comb begin
    for (int i = 0; i < 4; i++)
      byteLane[i] = busBe[i] && sizeOk && !dwNative && !pm1Word;
  end

  genvar k;
  generate
    for (k = 0; k < GPE_SPAN; k++) begin : gGpeDec
      localparam int OFFK = GPE_OFF + k;
      localparam int LANE = OFFK % 4;
      localparam logic [DW_W-1:0] DWK = DW_W'(OFFK / 4);
      assign gpeSel[k] = byteLane[LANE] && (dw == DWK);
    end
  endgenerate

  assign wrAcc = hit && busWe;
  assign rdAcc = hit && busRe;

  always_comb begin
    stb.wrSts = wrAcc && pm1Word && busBe[0];
    stb.wrEna = wrAcc && pm1Word && busBe[2];
    stb.wrSmi = wrAcc && dwNative;
    stb.rdSts = rdAcc && pm1Word && busBe[0];
    stb.rdEna = rdAcc && pm1Word && busBe[2];
    stb.rdSmi = rdAcc && dwNative;
    stb.gpeWr = wrAcc ? gpeSel : '0;
    stb.gpeRd = rdAcc ? gpeSel : '0;
  end

  p_zero_base_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (baseReg == '0) |-> (stb == '0));

  p_base_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |=> (baseReg[ADDR_W-1:BLK_BITS] == $past(baseIn[ADDR_W-1:BLK_BITS])));

  p_smi_dword_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSmi || stb.rdSmi) |-> (busBe == 4'b1111));

  p_pm1_no_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSts || stb.wrEna || stb.rdSts || stb.rdEna) |-> ($countones(busBe) >= 2));

endmodule

// File: rtl/pmData.sv
module pmData
  import pmEventPkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pmStrobeT               stb,
  input  logic [31:0]            wdata,
  input  logic [15:0]            evtSet,
  input  logic                   pwrDownReq,
  input  logic [GPE_BYTES*8-1:0] gpeEvt,
  output logic [31:0]            rdata,
  output logic                   sci
);

  localparam int GPE_BITS = GPE_BYTES * 8;

  logic [15:0]           pm1Sts, pm1Ena;
  logic [31:0]           smiEna;
  logic [2*GPE_BITS-1:0] gpeAll, gpeNxt;
  logic [TMR_W-1:0]      tmrCnt;
  logic                  tmrOvf, tmrArmed;
  logic [15:0]           setVec, stsClr;

  // top bit toggles on the edge leaving an all-ones low field
  assign tmrOvf   = &tmrCnt[TMR_W-2:0];
  assign tmrArmed = pm1Ena[TMR_BIT] && !pm1Sts[TMR_BIT];

  assign setVec = evtSet | (16'(tmrOvf) << TMR_BIT) | (16'(pwrDownReq) << PWR_BIT);
  assign stsClr = stb.wrSts ? wdata[15:0] : 16'h0000;

  always_comb begin
    gpeNxt = gpeAll;
    for (int k = 0; k < GPE_SPAN; k++) begin
      if (k < GPE_BYTES) begin
        gpeNxt[8*k +: 8] = (gpeAll[8*k +: 8] &
                            ~(stb.gpeWr[k] ? wdata[8*((GPE_OFF+k)%4) +: 8] : 8'h00)) |
                           gpeEvt[8*k +: 8];
      end else if (stb.gpeWr[k]) begin
        gpeNxt[8*k +: 8] = wdata[8*((GPE_OFF+k)%4) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pm1Sts <= '0;
      pm1Ena <= '0;
      smiEna <= '0;
      gpeAll <= '0;
      tmrCnt <= '0;
    end else begin
      tmrCnt <= tmrCnt + 1'b1;
      pm1Sts <= (pm1Sts & ~stsClr) | setVec;
      if (stb.wrEna) pm1Ena <= wdata[31:16];
      if (stb.wrSmi) smiEna <= wdata;
      gpeAll <= gpeNxt;
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (stb.rdSts) rdata[15:0]  = pm1Sts;
    if (stb.rdEna) rdata[31:16] = pm1Ena;
    if (stb.rdSmi) rdata        = smiEna;
    for (int k = 0; k < GPE_SPAN; k++)
      if (stb.gpeRd[k]) rdata[8*((GPE_OFF+k)%4) +: 8] |= gpeAll[8*k +: 8];
  end

  assign sci = |(pm1Sts & pm1Ena & SCI_MASK);

  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((pm1Sts & $past(evtSet)) == $past(evtSet)));

  p_pwr_btn_r3: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownReq |=> pm1Sts[PWR_BIT]);

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSts |=> ((pm1Sts & $past(wdata[15:0]) & ~$past(setVec)) == '0));

  p_sci_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((pm1Ena & SCI_MASK) == '0) |-> !sci);

  p_armed_timer_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tmrArmed && tmrOvf) |=> sci);

  p_smi_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrSmi |=> $stable(smiEna));

endmodule

// File: rtl/pmEventBlock.sv
module pmEventBlock
  import pmEventPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLK_BITS = 6,
  parameter int TMR_W    = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baseWe,
  input  logic [ADDR_W-1:0]      baseIn,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWe,
  input  logic                   busRe,
  input  logic [3:0]             busBe,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [15:0]            evtSet,
  input  logic                   pwrDownReq,
  input  logic [GPE_BYTES*8-1:0] gpeEvt,
  output logic                   sci
);

  pmStrobeT stb;

  pmCtrl #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baseWe  (baseWe),
    .baseIn  (baseIn),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .busBe   (busBe),
    .stb     (stb)
  );

  pmData #(.TMR_W(TMR_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (busWdata),
    .evtSet     (evtSet),
    .pwrDownReq (pwrDownReq),
    .gpeEvt     (gpeEvt),
    .rdata      (busRdata),
    .sci        (sci)
  );

endmodule

// File: tb/pmEventBlock_tb.sv
`timescale 1ns/1ps
module pmEventBlock_tb;

  localparam int TW = 8;
  localparam logic [15:0] B = 16'h0A40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWe = 1'b0;
  logic [15:0] baseIn = '0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] evtSet = '0;
  logic        pwrDownReq = 1'b0;
  logic [31:0] gpeEvt = '0;
  logic        sci;

  int nChk = 0, nFail = 0;
  logic        nextBaseWe = 1'b0;
  logic [15:0] nextBaseIn = '0;

  always #2 clk = ~clk;

  pmEventBlock #(.TMR_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseIn(baseIn),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .evtSet(evtSet),
    .pwrDownReq(pwrDownReq), .gpeEvt(gpeEvt), .sci(sci)
  );

  // reference model built from the requirements
  logic [15:0]   mSts = '0, mEna = '0, mBase = '0, mClr, mSet;
  logic [31:0]   mSmi = '0, mGSts = '0, mGEna = '0, mGClr;
  logic [TW-1:0] mCnt = '0;
  logic          mOvf;

  function automatic logic hitF(input logic [15:0] a);
    return (mBase != 16'h0) && (a[1:0] == 2'b00) && (a[15:6] == mBase[15:6]);
  endfunction

  function automatic logic beOk(input logic [3:0] be);
    return ($countones(be) == 1) || (be == 4'b0011) || (be == 4'b1100) || (be == 4'b1111);
  endfunction

  function automatic logic [31:0] expRead(input logic re, input logic [15:0] a,
                                          input logic [3:0] be);
    logic [31:0] r;
    r = 32'h0;
    if (re && hitF(a) && beOk(be)) begin
      case (a[5:0])
        6'h00: if ($countones(be) != 1) begin
                 if (be[0]) r[15:0]  = mSts;
                 if (be[2]) r[31:16] = mEna;
               end
        6'h30: if (be == 4'b1111) r = mSmi;
        6'h20: for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = mGSts[8*i +: 8];
        6'h24: for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = mGEna[8*i +: 8];
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic expSci();
    return |(mSts & mEna & 16'h0521);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSts = '0; mEna = '0; mBase = '0; mSmi = '0; mGSts = '0; mGEna = '0; mCnt = '0;
    end else begin
      mOvf = &mCnt[TW-2:0];
      mCnt = mCnt + 1'b1;
      mClr = '0; mGClr = '0;
      mSet = evtSet | {7'b0, pwrDownReq, 8'b0} | {15'b0, mOvf};
      if (busWe && hitF(busAddr) && beOk(busBe)) begin
        case (busAddr[5:0])
          6'h00: if ($countones(busBe) != 1) begin
                   if (busBe[0]) mClr = busWdata[15:0];
                   if (busBe[2]) mEna = busWdata[31:16];
                 end
          6'h30: if (busBe == 4'b1111) mSmi = busWdata;
          6'h20: for (int i = 0; i < 4; i++) if (busBe[i]) mGClr[8*i +: 8] = busWdata[8*i +: 8];
          6'h24: for (int i = 0; i < 4; i++) if (busBe[i]) mGEna[8*i +: 8] = busWdata[8*i +: 8];
          default: ;
        endcase
      end
      mSts  = (mSts & ~mClr) | mSet;
      mGSts = (mGSts & ~mGClr) | gpeEvt;
      if (baseWe) mBase = baseIn & 16'hFFC0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, compare before the rising edge
  task automatic step(input string tag, input logic we, input logic re,
                      input logic [15:0] a, input logic [3:0] be, input logic [31:0] d,
                      input logic [15:0] ev, input logic pwr, input logic [31:0] gev);
    @(negedge clk);
    busWe = we; busRe = re; busAddr = a; busBe = be; busWdata = d;
    evtSet = ev; pwrDownReq = pwr; gpeEvt = gev;
    baseWe = nextBaseWe; baseIn = nextBaseIn; nextBaseWe = 1'b0;
    #1;
    chk({tag, " rdata"}, busRdata, expRead(re, a, be));
    chk({tag, " sci"}, {31'b0, sci}, {31'b0, expSci()});
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b1, B, 4'b0011, 32'h0, 16'h0, 1'b0, 32'h0);
  endtask

  task automatic setBase(input logic [15:0] v);
    nextBaseWe = 1'b1; nextBaseIn = v;
    idle("R8 base load");
  endtask

  initial begin
    #200000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [15:0] offs [8];
    logic [3:0]  bes  [9];
    void'($urandom(1234));
    offs = '{16'h00, 16'h00, 16'h20, 16'h24, 16'h30, 16'h04, 16'h3C, 16'h21};
    bes  = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF, 4'hF, 4'h5};

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    chk("R1 sci after reset", {31'b0, sci}, 32'h0);
    step("R8 base zero", 1'b0, 1'b1, 16'h0000, 4'hF, 0, 0, 0, 0);
    chk("R8 base zero read", busRdata, 32'h0);
    setBase(B);
    step("R1 clear regs", 1'b0, 1'b1, B, 4'hF, 0, 0, 0, 0);
    chk("R1 clear regs", busRdata & 32'hFFFF_FFFE, 32'h0);

    step("R4 enable word", 1'b1, 1'b0, B, 4'b1100, 32'hFFFE_0000, 0, 0, 0);
    step("R4 enable read", 1'b0, 1'b1, B, 4'b1100, 0, 0, 0, 0);
    chk("R4 enable read", busRdata, 32'hFFFE_0000);

    step("R2 non-mask event", 1'b0, 1'b0, B, 4'h0, 0, 16'h0008, 0, 0);
    idle("R3 event set");
    chk("R3 event set", busRdata & 32'hFFFE, 32'h0008);
    chk("R2 non-mask no sci", {31'b0, sci}, 32'h0);

    step("R4 byte write", 1'b1, 1'b0, B, 4'b0001, 32'h08, 0, 0, 0);
    idle("R4 byte ignored");
    chk("R4 byte ignored", busRdata & 32'hFFFE, 32'h0008);
    step("R4 byte read", 1'b0, 1'b1, B, 4'b0001, 0, 0, 0, 0);
    chk("R4 byte read zero", busRdata, 32'h0);

    step("R3 w1c", 1'b1, 1'b0, B, 4'b0011, 32'h0008, 0, 0, 0);
    idle("R3 w1c");
    chk("R3 w1c cleared", busRdata & 32'hFFFE, 32'h0);

    step("R3 power button", 1'b0, 1'b0, B, 4'h0, 0, 0, 1'b1, 0);
    idle("R2 power button");
    chk("R2 power button sci", {31'b0, sci}, 32'h1);
    step("R3 set beats clear", 1'b1, 1'b0, B, 4'b0011, 32'h0100, 0, 1'b1, 0);
    idle("R3 set beats clear");
    chk("R3 set beats clear", busRdata & 32'h0100, 32'h0100);
    step("R3 clear pwr", 1'b1, 1'b0, B, 4'b0011, 32'h0100, 0, 0, 0);
    idle("R2 sci drop");
    chk("R2 sci drop", {31'b0, sci}, 32'h0);
    step("R2 global lock", 1'b0, 1'b0, B, 4'h0, 0, 16'h0020, 0, 0);
    idle("R2 global lock");
    chk("R2 global lock sci", {31'b0, sci}, 32'h1);
    step("R3 clear lock", 1'b1, 1'b0, B, 4'b0011, 32'h0020, 0, 0, 0);

    step("R5 smi write", 1'b1, 1'b0, B + 16'h30, 4'hF, 32'hDEAD_BEEF, 0, 0, 0);
    step("R5 smi narrow write", 1'b1, 1'b0, B + 16'h30, 4'b0011, 32'h1111, 0, 0, 0);
    step("R5 smi read", 1'b0, 1'b1, B + 16'h30, 4'hF, 0, 0, 0, 0);
    chk("R5 smi kept", busRdata, 32'hDEAD_BEEF);
    step("R5 smi narrow read", 1'b0, 1'b1, B + 16'h30, 4'b0011, 0, 0, 0, 0);
    chk("R5 smi narrow read zero", busRdata, 32'h0);

    step("R4 dword pm1", 1'b1, 1'b0, B, 4'hF, 32'h0002_FFFF, 0, 0, 0);
    step("R4 dword read", 1'b0, 1'b1, B, 4'hF, 0, 0, 0, 0);
    chk("R4 dword enable half", busRdata & 32'hFFFF_0000, 32'h0002_0000);

    step("R6 gpe event", 1'b0, 1'b0, B, 4'h0, 0, 0, 0, 32'h0000_A500);
    step("R6 gpe read", 1'b0, 1'b1, B + 16'h20, 4'b0011, 0, 0, 0, 0);
    chk("R6 gpe status", busRdata, 32'h0000_A500);
    step("R6 gpe w1c", 1'b1, 1'b0, B + 16'h20, 4'b0010, 32'h0000_8000, 0, 0, 0);
    step("R6 gpe read", 1'b0, 1'b1, B + 16'h20, 4'b0011, 0, 0, 0, 0);
    chk("R6 gpe byte clear", busRdata, 32'h0000_2500);
    step("R6 gpe enable", 1'b1, 1'b0, B + 16'h24, 4'hF, 32'h1122_3344, 0, 0, 0);
    step("R6 gpe enable read", 1'b0, 1'b1, B + 16'h24, 4'b1000, 0, 0, 0, 0);
    chk("R6 gpe enable byte", busRdata, 32'h1100_0000);

    step("R7 unmapped write", 1'b1, 1'b0, B + 16'h3C, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    step("R7 unmapped read", 1'b0, 1'b1, B + 16'h3C, 4'hF, 0, 0, 0, 0);
    chk("R7 unmapped zero", busRdata, 32'h0);
    step("R7 bad enables", 1'b1, 1'b0, B + 16'h24, 4'b0101, 32'h0, 0, 0, 0);
    step("R7 bad enables", 1'b0, 1'b1, B + 16'h24, 4'hF, 0, 0, 0, 0);
    chk("R7 bad enables ignored", busRdata, 32'h1122_3344);
    step("R7 misaligned", 1'b0, 1'b1, B + 16'h25, 4'hF, 0, 0, 0, 0);
    chk("R7 misaligned zero", busRdata, 32'h0);

    setBase(16'h0000);
    step("R8 window off", 1'b1, 1'b1, B + 16'h30, 4'hF, 32'h0, 0, 0, 0);
    chk("R8 window off read", busRdata, 32'h0);
    setBase(16'h0A57);
    step("R8 unaligned base", 1'b0, 1'b1, B + 16'h30, 4'hF, 0, 0, 0, 0);
    chk("R8 unaligned base", busRdata, 32'hDEAD_BEEF);

    step("R9 timer prep", 1'b1, 1'b0, B, 4'hF, 32'h0000_FFFF, 0, 0, 0);
    for (int i = 0; i < (1 << (TW - 1)) + 2; i++) idle("R9 timer wait");
    chk("R9 timer flag", busRdata & 32'h1, 32'h1);
    chk("R9 timer no sci", {31'b0, sci}, 32'h0);
    step("R9 timer enable", 1'b1, 1'b0, B, 4'b1100, 32'h0001_0000, 0, 0, 0);
    idle("R9 timer sci");
    chk("R9 timer sci", {31'b0, sci}, 32'h1);

    for (int n = 0; n < 700; n++) begin
      logic [15:0] a;
      logic [15:0] ev;
      logic [31:0] gev;
      a   = ($urandom % 12 == 0) ? (B + 16'h40 + offs[$urandom % 8]) : (B + offs[$urandom % 8]);
      ev  = ($urandom % 8 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      gev = ($urandom % 8 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      if ($urandom % 50 == 0) begin
        nextBaseWe = 1'b1;
        case ($urandom % 3)
          0: nextBaseIn = 16'h0000;
          1: nextBaseIn = B;
          default: nextBaseIn = 16'h0A57;
        endcase
      end
      step("R7 random", 1'($urandom), 1'($urandom), a, bes[$urandom % 9], $urandom,
           ev, ($urandom % 16 == 0), gev);
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule